// File: doc/BRIEF.md
# Packet-Filter ALU Execution Stage

This block is the arithmetic and logic stage of a small 64-bit register-machine processor for packet filtering. Each cycle it may take one instruction: the 8-bit opcode, the current value of the destination register, the value of the source register and the 32-bit immediate. One cycle later it returns the value to write back, a write-enable and an illegal-instruction flag. The register file, instruction fetch and memory access are handled by other blocks.

The opcode byte does three jobs. Its class bits pick a 32-bit or a 64-bit operation. Its source bit picks the immediate or the source register as the second operand. Its upper nibble picks one of fourteen operations. The operations are add, subtract, multiply, unsigned divide, unsigned modulo, the bitwise operations, move, negate, three shifts and byte-order conversion.

Top module: `pf_alu_exec`

## Requirements
- R1: Opcode bits [2:0] give the class. 3'h4 is the 32-bit class and 3'h7 is the 64-bit class. Any other class value raises the illegal flag and does not write.
- R2: Opcode bit 3 selects the second operand: 0 selects the immediate and 1 selects the source register. In the 64-bit class the immediate is sign-extended from bit 31.
- R3: In the 32-bit class both operands are cut to their low 32 bits before the operation, and the 32-bit result is zero-extended to 64 bits. Byte-order conversion (0xD) is the one exception.
- R4: The operation is given by opcode bits [7:4]: 0x0 add, 0x1 subtract, 0x2 multiply, 0x4 or, 0x5 and, 0xA xor, 0xB move (copies the second operand), 0x8 negate (two's complement of the destination; the second operand is ignored). All of these wrap modulo the operand width.
- R5: Bits [7:4] = 0x6 is a left shift, 0x7 a logical right shift and 0xC a sign-extending right shift. The shift amount is the second operand masked to 5 bits in the 32-bit class and to 6 bits in the 64-bit class.
- R6: Bits [7:4] = 0x3 is unsigned division. A zero divisor gives a result of 0.
- R7: Bits [7:4] = 0x9 is unsigned modulo. A zero divisor gives back the destination operand: the full value in the 64-bit class, and its zero-extended low half in the 32-bit class.
- R8: Bits [7:4] = 0xD is byte-order conversion of the destination. The immediate value 16, 32 or 64 gives the width in bits, in either class. Source bit 1 reverses the byte order within that width. Source bit 0 keeps the byte order. In both cases the bits above the width are cleared. Any other immediate value is illegal.
- R9: Bits [7:4] = 0xE or 0xF raise the illegal flag and do not write.
- R10: The result, the write-enable and the illegal flag are registered and appear one cycle after the issue strobe. If no instruction is issued, or the instruction is illegal, write-enable is low and the result is 0. Write-enable and the illegal flag are never both high. Reset clears all three outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | An instruction is presented this cycle |
| opcode_i | input | 8 | Operation [7:4], source select [3], class [2:0] |
| dst_i | input | 64 | Destination register value |
| src_i | input | 64 | Source register value |
| imm_i | input | 32 | Immediate field |
| result_o | output | 64 | Value to write back to the destination register |
| wr_en_o | output | 1 | Write-back enable |
| illegal_o | output | 1 | Illegal instruction detected |

## Verification
Some cases are hard to reach with uniform random operands. A zero divisor almost never comes up, a shift amount rarely lands exactly on the masking boundary, and the byte-order operation needs its immediate to be exactly 16, 32 or 64. The stimulus draws operands from a mix of full-width random values, very small values, zero and values with the top bit set. For byte-order conversion it picks the immediate mostly from the three legal widths. Directed vectors then cover divide and modulo by zero in both classes, shifts by 31, 32, 63 and 64, negative arithmetic shifts, sign extension of a negative immediate, and each illegal class and operation.

// File: rtl/pf_alu_pkg.sv
package pf_alu_pkg;

    localparam int XLEN   = 64;
    localparam int HALF   = XLEN / 2;
    localparam int IMMW   = 32;
    localparam int SHW    = $clog2(XLEN);
    localparam int SHW_N  = $clog2(HALF);
    localparam int NBSW   = $clog2(XLEN) - 3;   // byte-swap widths: 16, 32, 64

    localparam logic [2:0] CLS_NARROW = 3'h4;
    localparam logic [2:0] CLS_WIDE   = 3'h7;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_MUL  = 4'h2,
        OP_DIV  = 4'h3,
        OP_OR   = 4'h4,
        OP_AND  = 4'h5,
        OP_LSH  = 4'h6,
        OP_RSH  = 4'h7,
        OP_NEG  = 4'h8,
        OP_MOD  = 4'h9,
        OP_XOR  = 4'hA,
        OP_MOV  = 4'hB,
        OP_ARSH = 4'hC,
        OP_END  = 4'hD
    } alu_op_e;

    typedef enum logic [1:0] {
        BW_16 = 2'd0,
        BW_32 = 2'd1,
        BW_64 = 2'd2
    } bswap_w_e;

    typedef struct packed {
        alu_op_e  op;
        logic     narrow;
        logic     use_reg;
        bswap_w_e end_w;
        logic     legal;
    } dec_t;

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic            wr_en;
        logic            illegal;
    } stage_t;

endpackage

// File: rtl/pf_alu_decode.sv
module pf_alu_decode
    import pf_alu_pkg::*;
(
    input  logic [7:0]      opcode_i,
    input  logic [IMMW-1:0] imm_i,
    output dec_t            dec_o
);

    logic     cls_ok;
    logic     op_ok;
    logic     width_ok;
    bswap_w_e width_sel;

    always_comb begin
        cls_ok = (opcode_i[2:0] == CLS_NARROW) || (opcode_i[2:0] == CLS_WIDE);
        op_ok  = (opcode_i[7:4] <= OP_END);

        width_ok  = 1'b1;
        width_sel = BW_64;
        case (imm_i)
            IMMW'(16): width_sel = BW_16;
            IMMW'(32): width_sel = BW_32;
            IMMW'(64): width_sel = BW_64;
            default:   width_ok  = 1'b0;
        endcase

        dec_o.op      = alu_op_e'(opcode_i[7:4]);
        dec_o.narrow  = (opcode_i[2:0] == CLS_NARROW);
        dec_o.use_reg = opcode_i[3];
        dec_o.end_w   = width_sel;
        dec_o.legal   = cls_ok && op_ok &&
                        ((opcode_i[7:4] != OP_END) || width_ok);
    end

endmodule

// File: rtl/pf_alu_bswap.sv
module pf_alu_bswap
    import pf_alu_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int NV = NBSW
) (
    input  logic [W-1:0] val_i,
    input  bswap_w_e     width_i,
    input  logic         swap_i,
    output logic [W-1:0] val_o
);

    logic [W-1:0] swapped [NV];
    logic [W-1:0] trimmed [NV];

    for (genvar g = 0; g < NV; g++) begin : g_width
        localparam int NB = 2 << g;
        logic [W-1:0] sw_g;
        for (genvar i = 0; i < NB; i++) begin : g_byte
            assign sw_g[8*i +: 8] = val_i[8*(NB-1-i) +: 8];
        end
        if (NB * 8 < W) begin : g_pad
            assign sw_g[W-1:NB*8]       = '0;
            assign trimmed[g][W-1:NB*8] = '0;
        end
        assign trimmed[g][NB*8-1:0] = val_i[NB*8-1:0];
        assign swapped[g]           = sw_g;
    end

    always_comb begin
        case (width_i)
            BW_16:   val_o = swap_i ? swapped[0] : trimmed[0];
            BW_32:   val_o = swap_i ? swapped[1] : trimmed[1];
            default: val_o = swap_i ? swapped[NV-1] : trimmed[NV-1];
        endcase
    end

endmodule

// File: rtl/pf_alu_arith.sv
module pf_alu_arith
    import pf_alu_pkg::*;
(
    input  alu_op_e         op_i,
    input  logic            narrow_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] raw_o
);

    logic [SHW-1:0]  shamt;
    logic [XLEN-1:0] a_sx;

    always_comb begin
        shamt = narrow_i ? SHW'(b_i[SHW_N-1:0]) : b_i[SHW-1:0];
        a_sx  = narrow_i ? {{HALF{a_i[HALF-1]}}, a_i[HALF-1:0]} : a_i;

        case (op_i)
            OP_ADD:  raw_o = a_i + b_i;
            OP_SUB:  raw_o = a_i - b_i;
            OP_MUL:  raw_o = a_i * b_i;
            OP_DIV:  raw_o = (b_i == '0) ? '0  : a_i / b_i;
            OP_MOD:  raw_o = (b_i == '0) ? a_i : a_i % b_i;
            OP_OR:   raw_o = a_i | b_i;
            OP_AND:  raw_o = a_i & b_i;
            OP_XOR:  raw_o = a_i ^ b_i;
            OP_MOV:  raw_o = b_i;
            OP_NEG:  raw_o = '0 - a_i;
            OP_LSH:  raw_o = a_i << shamt;
            OP_RSH:  raw_o = a_i >> shamt;
            OP_ARSH: raw_o = $unsigned($signed(a_sx) >>> shamt);
            default: raw_o = '0;
        endcase
    end

endmodule

// File: rtl/pf_alu_exec.sv
module pf_alu_exec
    import pf_alu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_i,
    input  logic [7:0]      opcode_i,
    input  logic [XLEN-1:0] dst_i,
    input  logic [XLEN-1:0] src_i,
    input  logic [IMMW-1:0] imm_i,
    output logic [XLEN-1:0] result_o,
    output logic            wr_en_o,
    output logic            illegal_o
);

    dec_t            dec;
    logic [XLEN-1:0] imm_x;
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] a_op;
    logic [XLEN-1:0] b_op;
    logic [XLEN-1:0] arith_raw;
    logic [XLEN-1:0] bswap_val;
    logic [XLEN-1:0] value;
    stage_t          stage_d;
    stage_t          stage_q;

    pf_alu_decode u_decode (
        .opcode_i (opcode_i),
        .imm_i    (imm_i),
        .dec_o    (dec)
    );

    // operand preparation: immediate extension and narrow truncation
    always_comb begin
        imm_x  = dec.narrow ? {{(XLEN-IMMW){1'b0}}, imm_i}
                            : {{(XLEN-IMMW){imm_i[IMMW-1]}}, imm_i};
        opnd_b = dec.use_reg ? src_i : imm_x;
        a_op   = dec.narrow ? {{HALF{1'b0}}, dst_i[HALF-1:0]}  : dst_i;
        b_op   = dec.narrow ? {{HALF{1'b0}}, opnd_b[HALF-1:0]} : opnd_b;
    end

    pf_alu_arith u_arith (
        .op_i     (dec.op),
        .narrow_i (dec.narrow),
        .a_i      (a_op),
        .b_i      (b_op),
        .raw_o    (arith_raw)
    );

    pf_alu_bswap u_bswap (
        .val_i   (dst_i),
        .width_i (dec.end_w),
        .swap_i  (dec.use_reg),
        .val_o   (bswap_val)
    );

    always_comb begin
        if (dec.op == OP_END) begin
            value = bswap_val;
        end else if (dec.narrow) begin
            value = {{HALF{1'b0}}, arith_raw[HALF-1:0]};
        end else begin
            value = arith_raw;
        end

        stage_d.wr_en   = issue_i && dec.legal;
        stage_d.illegal = issue_i && !dec.legal;
        stage_d.result  = stage_d.wr_en ? value : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign result_o  = stage_q.result;
    assign wr_en_o   = stage_q.wr_en;
    assign illegal_o = stage_q.illegal;

    // R10
    wr_ill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_o && illegal_o));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> (!wr_en_o && !illegal_o && result_o == '0));

    // R1
    bad_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && opcode_i[2:0] != CLS_NARROW && opcode_i[2:0] != CLS_WIDE)
        |=> (illegal_o && !wr_en_o));

    // R9
    bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && opcode_i[7:5] == 3'b111) |=> (illegal_o && !wr_en_o));

    // R3
    narrow_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && opcode_i[2:0] == CLS_NARROW && opcode_i[7:4] != OP_END)
        |=> (result_o[XLEN-1:HALF] == '0));

    // R2
    mov_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && opcode_i == 8'hBF) |=> (wr_en_o && result_o == $past(src_i)));

    // R7
    mod_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && opcode_i == 8'h9F && src_i == '0)
        |=> (result_o == $past(dst_i)));

endmodule

// File: tb/pf_alu_exec_tb_top.sv
`timescale 1ns/1ps
module pf_alu_exec_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [7:0]  opcode_i = '0;
    logic [63:0] dst_i = '0;
    logic [63:0] src_i = '0;
    logic [31:0] imm_i = '0;
    logic [63:0] result_o;
    logic        wr_en_o;
    logic        illegal_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pf_alu_exec dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_i   (issue_i),
        .opcode_i  (opcode_i),
        .dst_i     (dst_i),
        .src_i     (src_i),
        .imm_i     (imm_i),
        .result_o  (result_o),
        .wr_en_o   (wr_en_o),
        .illegal_o (illegal_o)
    );

    // expected {wr, ill, result} from the requirements
    function automatic logic [65:0] model(input logic iss, input logic [7:0] op,
                                          input logic [63:0] d, input logic [63:0] s,
                                          input logic [31:0] im);
        logic        w32;
        logic [63:0] a, b, r;
        logic [5:0]  sh;
        logic signed [31:0] t32;
        logic [15:0] h;
        logic [31:0] wd;
        if (!iss) return {2'b00, 64'd0};
        if (op[2:0] != 3'h4 && op[2:0] != 3'h7) return {2'b01, 64'd0};
        if (op[7:4] > 4'hD) return {2'b01, 64'd0};
        w32 = (op[2:0] == 3'h4);
        b = op[3] ? s : (w32 ? {32'd0, im} : {{32{im[31]}}, im});
        a = d;
        if (w32) begin
            a = {32'd0, d[31:0]};
            b = {32'd0, b[31:0]};
        end
        sh = w32 ? {1'b0, b[4:0]} : b[5:0];
        case (op[7:4])
            4'h0: r = a + b;
            4'h1: r = a - b;
            4'h2: r = a * b;
            4'h3: r = (b == 0) ? 64'd0 : a / b;
            4'h4: r = a | b;
            4'h5: r = a & b;
            4'h6: r = a << sh;
            4'h7: r = a >> sh;
            4'h8: r = -a;
            4'h9: r = (b == 0) ? a : a % b;
            4'hA: r = a ^ b;
            4'hB: r = b;
            4'hC: begin
                if (w32) begin
                    t32 = $signed(a[31:0]) >>> sh;
                    r = {32'd0, t32};
                end else begin
                    r = $signed(a) >>> sh;
                end
            end
            default: begin
                if (im == 32'd16) begin
                    h = d[15:0];
                    r = {48'd0, op[3] ? {<<8{h}} : h};
                end else if (im == 32'd32) begin
                    wd = d[31:0];
                    r = {32'd0, op[3] ? {<<8{wd}} : wd};
                end else if (im == 32'd64) begin
                    r = op[3] ? {<<8{d}} : d;
                end else begin
                    return {2'b01, 64'd0};
                end
                return {2'b10, r};
            end
        endcase
        if (w32) r = {32'd0, r[31:0]};
        return {2'b10, r};
    endfunction

    task automatic apply(input logic iss, input logic [7:0] op, input logic [63:0] d,
                         input logic [63:0] s, input logic [31:0] im, input string tag);
        logic [65:0] exp;
        @(negedge clk);
        issue_i = iss; opcode_i = op; dst_i = d; src_i = s; imm_i = im;
        exp = model(iss, op, d, s, im);
        @(posedge clk);
        #2;
        n_vec++;
        if ({wr_en_o, illegal_o, result_o} !== exp) begin
            n_fail++;
            $display("FAIL %s op=%02h dst=%h src=%h imm=%h: got wr=%b ill=%b res=%h, expected wr=%b ill=%b res=%h",
                     tag, op, d, s, im, wr_en_o, illegal_o, result_o, exp[65], exp[64], exp[63:0]);
        end
    endtask

    function automatic logic [63:0] pick_val();
        case ($urandom % 5)
            0: return 64'd0;
            1: return 64'($urandom % 8);
            2: return {1'b1, 31'($urandom), 32'($urandom)};
            default: return {32'($urandom), 32'($urandom)};
        endcase
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2;
        n_vec++;
        if (result_o !== 64'd0 || wr_en_o !== 1'b0 || illegal_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 reset: got wr=%b ill=%b res=%h, expected 0 0 0",
                     wr_en_o, illegal_o, result_o);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // directed corner cases
        apply(1, 8'h0F, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, "R4 add wrap 64");
        apply(1, 8'h0C, 64'h1_FFFF_FFFF, 64'd1, 0, "R3 add wrap 32");
        apply(1, 8'h07, 64'd5, 0, 32'hFFFF_FFFE, "R2 sign-ext imm");
        apply(1, 8'h04, 64'd5, 0, 32'hFFFF_FFFE, "R2 R3 zero-ext imm");
        apply(1, 8'hB7, 64'd9, 64'd7, 32'h8000_0000, "R2 mov imm");
        apply(1, 8'h87, 64'd1, 64'd3, 0, "R4 neg 64");
        apply(1, 8'h84, 64'h1234_0000_0001, 64'd3, 0, "R4 neg 32");
        apply(1, 8'h1F, 64'd3, 64'd5, 0, "R4 sub borrow");
        apply(1, 8'h2C, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 0, "R4 mul 32");
        apply(1, 8'h6F, 64'd1, 64'd63, 0, "R5 lsh 63");
        apply(1, 8'h6F, 64'd1, 64'd64, 0, "R5 lsh mask 64");
        apply(1, 8'h6C, 64'd1, 64'd32, 0, "R5 lsh mask 32");
        apply(1, 8'h6C, 64'd1, 64'd31, 0, "R5 lsh 31");
        apply(1, 8'hCC, 64'h8000_0000, 64'd4, 0, "R5 arsh neg 32");
        apply(1, 8'hCF, 64'h8000_0000_0000_0000, 64'd63, 0, "R5 arsh neg 64");
        apply(1, 8'h7F, 64'h8000_0000_0000_0000, 64'd63, 0, "R5 rsh 64");
        apply(1, 8'h3F, 64'd100, 64'd0, 0, "R6 div zero");
        apply(1, 8'h3C, 64'd100, 64'h1_0000_0000, 0, "R6 div zero low half");
        apply(1, 8'h3F, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 0, "R6 unsigned div");
        apply(1, 8'h9F, 64'hDEAD_BEEF_0000_1111, 64'd0, 0, "R7 mod zero 64");
        apply(1, 8'h9C, 64'hDEAD_BEEF_0000_1111, 64'd0, 0, "R7 mod zero 32");
        apply(1, 8'h97, 64'd17, 0, 32'd5, "R7 mod");
        apply(1, 8'hDC, 64'h1122_3344_5566_7788, 0, 32'd16, "R8 swap16");
        apply(1, 8'hDC, 64'h1122_3344_5566_7788, 0, 32'd32, "R8 swap32");
        apply(1, 8'hDC, 64'h1122_3344_5566_7788, 0, 32'd64, "R8 swap64");
        apply(1, 8'hD4, 64'h1122_3344_5566_7788, 0, 32'd16, "R8 trim16");
        apply(1, 8'hD7, 64'h1122_3344_5566_7788, 0, 32'd64, "R8 keep64");
        apply(1, 8'hDC, 64'h1122_3344_5566_7788, 0, 32'd8, "R8 bad width");
        apply(1, 8'hE7, 64'd1, 64'd1, 0, "R9 op E");
        apply(1, 8'hFF, 64'd1, 64'd1, 0, "R9 op F");
        apply(1, 8'h05, 64'd1, 64'd1, 0, "R1 class 5");
        apply(1, 8'h00, 64'd1, 64'd1, 0, "R1 class 0");
        apply(1, 8'h5F, 64'hF0F0, 64'h0FF0, 0, "R4 and");
        apply(1, 8'h4F, 64'hF0F0, 64'h0FF0, 0, "R4 or");
        apply(1, 8'hAF, 64'hF0F0, 64'h0FF0, 0, "R4 xor");
        apply(0, 8'h0F, 64'd1, 64'd1, 0, "R10 no issue");

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic [7:0]  op;
            logic [31:0] im;
            logic [2:0]  cls;
            cls = ($urandom % 10 < 8) ? (($urandom % 2) ? 3'h7 : 3'h4) : 3'($urandom);
            op  = {4'($urandom), 1'($urandom), cls};
            im  = ($urandom % 2) ? 32'($urandom) : 32'(pick_val());
            if (op[7:4] == 4'hD && ($urandom % 8) != 0) begin
                case ($urandom % 3)
                    0: im = 32'd16;
                    1: im = 32'd32;
                    default: im = 32'd64;
                endcase
            end
            apply(($urandom % 16) != 0, op, pick_val(), pick_val(), im, "R4 R10 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule